// File: doc/BRIEF.md
# Unsigned Divide Execution Unit

A multi-cycle unsigned integer divider intended to sit beside the integer pipeline of a processor core. An operation supplies a divisor, a dividend, two destination register indices (one for the quotient, one for the remainder) and the five incoming condition flags. The unit produces one quotient bit per clock using restoring shift-subtract. When it finishes, it presents up to two register write requests and the updated flags for one cycle, together with a `done` pulse.

Operations enter over a valid/ready handshake. `in_ready` is high only while the unit is idle. An operation is taken on a rising edge where both `in_valid` and `in_ready` are high. While the unit is working, `in_ready` is low and anything offered on the inputs is dropped rather than queued; the producer must hold its request until `in_ready` returns. The result side has no back-pressure: the register file must take both write ports in the cycle that `done` is high.

A zero divisor is caught when the operation is accepted and finishes at once. It raises the overflow flag and writes no register. If both destinations name the same register, only the remainder is written. Register index 0 is treated as a constant-zero register and is never written.

Top module: `udiv_unit`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle. An operation is accepted only on an edge with `in_valid` and `in_ready` both high. `in_valid` seen while the unit is busy starts nothing and changes no result.
- R2: For a non-zero divisor, `quo_wdata` equals dividend / divisor and `rem_wdata` equals dividend mod divisor (32-bit unsigned), using the operands captured at acceptance.
- R3: `done` is high for exactly one cycle. For a non-zero divisor that is the cycle following the 32nd rising edge after the accepting edge.
- R4: For a zero divisor, `done` is high in the cycle right after the accepting edge, with both write enables low. `flags_out` equals `flags_in` with the OV bit forced to 1.
- R5: Flag bit positions are Z=bit 0, S=bit 1, OV=bit 2, CY=bit 3, SAT=bit 4. For a non-zero divisor, OV=0, Z=1 only when the quotient is zero (regardless of the remainder), S equals quotient bit 31, and CY and SAT are copied from `flags_in`.
- R6: When the quotient and remainder indices are equal, `quo_we` stays low and only the remainder is written to that register.
- R7: No write enable is ever raised for register index 0.
- R8: Write enables are high only while `done` is high. After synchronous reset, `in_ready` is 1, `done` is 0 and no write is pending.
- R9: A zero dividend with a non-zero divisor completes normally, writing quotient 0 and remainder 0 with Z=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation will be taken |
| divisor | input | 32 | Divisor operand |
| dividend | input | 32 | Dividend operand |
| quo_idx | input | 5 | Destination register for the quotient |
| rem_idx | input | 5 | Destination register for the remainder |
| flags_in | input | 5 | Incoming flags {SAT,CY,OV,S,Z} |
| done | output | 1 | One-cycle completion pulse |
| quo_we | output | 1 | Quotient write enable |
| quo_widx | output | 5 | Quotient write index |
| quo_wdata | output | 32 | Quotient write data |
| rem_we | output | 1 | Remainder write enable |
| rem_widx | output | 5 | Remainder write index |
| rem_wdata | output | 32 | Remainder write data |
| flags_out | output | 5 | Updated flags, valid with `done` |

## Verification
The hardest case to reach from the ports is an operation offered while the divider is mid-run. The stimulus issues a normal divide and then, for several cycles during its iterations, holds `in_valid` high with a zero divisor and different indices. The scoreboard then sees exactly one completion, carrying the original operands' results. The same-index and index-0 cases are reached by choosing destination indices, and the two zero-divisor cases use all-clear and all-set incoming flags.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  localparam int FLAG_W = 5;
  localparam int FZ   = 0;
  localparam int FS   = 1;
  localparam int FOV  = 2;
  localparam int FCY  = 3;
  localparam int FSAT = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl import udiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic dvs_zero,
  output logic ready,
  output logic step,
  output logic done
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  div_state_e state;
  logic [CNT_W-1:0] iter;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          iter <= '0;
          if (accept) state <= dvs_zero ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          iter <= iter + 1'b1;
          if (iter == LAST) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready = (state == ST_IDLE);
  assign step  = (state == ST_RUN);
  assign done  = (state == ST_DONE);
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] dvs_q;
  logic [W:0]   trial;
  logic [W:0]   diff;
  logic         fits;

  // Shift the next dividend bit into the partial remainder, then trial-subtract.
  assign trial = {rem, quo[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = ~diff[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs_q <= '0;
      quo   <= '0;
      rem   <= '0;
    end else if (load) begin
      dvs_q <= divisor;
      quo   <= dividend;
      rem   <= '0;
    end else if (step) begin
      quo <= {quo[W-2:0], fits};
      rem <= fits ? diff[W-1:0] : trial[W-1:0];
    end
  end
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags import udiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic [FLAG_W-1:0] flg_in,
  input  logic              dz,
  input  logic [W-1:0]      quo,
  output logic [FLAG_W-1:0] flg_out
);
  always_comb begin
    flg_out = flg_in;
    if (dz) begin
      flg_out[FOV] = 1'b1;
    end else begin
      flg_out[FOV] = 1'b0;
      flg_out[FZ]  = (quo == '0);
      flg_out[FS]  = quo[W-1];
    end
  end
endmodule

// File: rtl/udiv_wb.sv
module udiv_wb #(
  parameter int W            = 32,
  parameter int IDX_W        = 5,
  parameter bit HAS_ZERO_REG = 1'b1
) (
  input  logic             done,
  input  logic             dz,
  input  logic [IDX_W-1:0] qidx,
  input  logic [IDX_W-1:0] ridx,
  input  logic [W-1:0]     quo,
  input  logic [W-1:0]     rem,
  output logic             quo_we,
  output logic [IDX_W-1:0] quo_widx,
  output logic [W-1:0]     quo_wdata,
  output logic             rem_we,
  output logic [IDX_W-1:0] rem_widx,
  output logic [W-1:0]     rem_wdata
);
  logic q_ok, r_ok;

  generate
    if (HAS_ZERO_REG) begin : g_zero_reg
      assign q_ok = (qidx != '0);
      assign r_ok = (ridx != '0);
    end else begin : g_no_zero_reg
      assign q_ok = 1'b1;
      assign r_ok = 1'b1;
    end
  endgenerate

  // The remainder wins a collision on the same destination.
  assign quo_we    = done & ~dz & q_ok & (qidx != ridx);
  assign rem_we    = done & ~dz & r_ok;
  assign quo_widx  = qidx;
  assign rem_widx  = ridx;
  assign quo_wdata = quo;
  assign rem_wdata = rem;
endmodule

// File: rtl/udiv_unit.sv
module udiv_unit import udiv_pkg::*; #(
  parameter int W            = 32,
  parameter int IDX_W        = 5,
  parameter bit HAS_ZERO_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      divisor,
  input  logic [W-1:0]      dividend,
  input  logic [IDX_W-1:0]  quo_idx,
  input  logic [IDX_W-1:0]  rem_idx,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              done,
  output logic              quo_we,
  output logic [IDX_W-1:0]  quo_widx,
  output logic [W-1:0]      quo_wdata,
  output logic              rem_we,
  output logic [IDX_W-1:0]  rem_widx,
  output logic [W-1:0]      rem_wdata,
  output logic [FLAG_W-1:0] flags_out
);
  logic              accept, dvs_zero, step;
  logic              dz_q;
  logic [IDX_W-1:0]  qidx_q, ridx_q;
  logic [FLAG_W-1:0] flg_q;
  logic [W-1:0]      quo, rem;

  assign accept   = in_valid & in_ready;
  assign dvs_zero = (divisor == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dz_q   <= 1'b0;
      qidx_q <= '0;
      ridx_q <= '0;
      flg_q  <= '0;
    end else if (accept) begin
      dz_q   <= dvs_zero;
      qidx_q <= quo_idx;
      ridx_q <= rem_idx;
      flg_q  <= flags_in;
    end
  end

  udiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .dvs_zero(dvs_zero),
    .ready(in_ready), .step(step), .done(done)
  );

  udiv_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .dividend(dividend), .divisor(divisor), .quo(quo), .rem(rem)
  );

  udiv_flags #(.W(W)) u_flags (
    .flg_in(flg_q), .dz(dz_q), .quo(quo), .flg_out(flags_out)
  );

  udiv_wb #(.W(W), .IDX_W(IDX_W), .HAS_ZERO_REG(HAS_ZERO_REG)) u_wb (
    .done(done), .dz(dz_q), .qidx(qidx_q), .ridx(ridx_q),
    .quo(quo), .rem(rem),
    .quo_we(quo_we), .quo_widx(quo_widx), .quo_wdata(quo_wdata),
    .rem_we(rem_we), .rem_widx(rem_widx), .rem_wdata(rem_wdata)
  );
endmodule

// File: rtl/udiv_unit_chk.sv
module udiv_unit_chk #(
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     divisor,
  input logic             done,
  input logic             quo_we,
  input logic [IDX_W-1:0] quo_widx,
  input logic             rem_we,
  input logic [IDX_W-1:0] rem_widx,
  input logic [W-1:0]     rem_wdata,
  input logic             ov_out
);
  int           since_acc;
  logic         zcap;
  logic [W-1:0] dcap;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= 0;
      zcap      <= 1'b0;
      dcap      <= '1;
    end else if (in_valid && in_ready) begin
      since_acc <= 0;
      zcap      <= (divisor == '0);
      dcap      <= divisor;
    end else begin
      since_acc <= since_acc + 1;
    end
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (rst)
    rem_we |-> (rem_wdata < dcap));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (since_acc == (zcap ? 0 : W)));

  assert_zero_div_fast_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && divisor == '0) |=> (done && !quo_we && !rem_we && ov_out));

  assert_ov_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !zcap) |-> !ov_out);

  assert_same_idx_R6: assert property (@(posedge clk) disable iff (rst)
    (done && quo_widx == rem_widx) |-> !quo_we);

  assert_no_reg0_R7: assert property (@(posedge clk) disable iff (rst)
    (quo_we |-> quo_widx != '0) and (rem_we |-> rem_widx != '0));

  assert_we_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    (quo_we || rem_we) |-> done);
endmodule

bind udiv_unit udiv_unit_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .divisor(divisor), .done(done), .quo_we(quo_we), .quo_widx(quo_widx),
  .rem_we(rem_we), .rem_widx(rem_widx), .rem_wdata(rem_wdata),
  .ov_out(flags_out[udiv_pkg::FOV])
);

// File: tb/sim_udiv_unit.sv
module sim_udiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LAT_RUN = 33;

  typedef struct {
    logic        qwe;
    logic [4:0]  qi;
    logic [31:0] q;
    logic        rwe;
    logic [4:0]  ri;
    logic [31:0] r;
    logic [4:0]  fl;
    longint      due;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] divisor = '0, dividend = '0;
  logic [4:0]  quo_idx = '0, rem_idx = '0, flags_in = '0;
  logic        done, quo_we, rem_we;
  logic [4:0]  quo_widx, rem_widx, flags_out;
  logic [31:0] quo_wdata, rem_wdata;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint cyc     = 0;
  exp_t   sb[$];
  exp_t   got;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udiv_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .divisor(divisor), .dividend(dividend), .quo_idx(quo_idx), .rem_idx(rem_idx),
    .flags_in(flags_in), .done(done), .quo_we(quo_we), .quo_widx(quo_widx),
    .quo_wdata(quo_wdata), .rem_we(rem_we), .rem_widx(rem_widx),
    .rem_wdata(rem_wdata), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] dvs, input logic [31:0] dvd,
                      input logic [4:0] qi, input logic [4:0] ri, input logic [4:0] fl);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; divisor = dvs; dividend = dvd;
    quo_idx = qi; rem_idx = ri; flags_in = fl;
    @(posedge clk);
    e.qi  = qi;
    e.ri  = ri;
    e.qwe = (dvs != 0) && (qi != 0) && (qi != ri);
    e.rwe = (dvs != 0) && (ri != 0);
    e.q   = (dvs != 0) ? dvd / dvs : 32'h0;
    e.r   = (dvs != 0) ? dvd % dvs : 32'h0;
    if (dvs == 0) e.fl = fl | 5'b00100;
    else          e.fl = {fl[4], fl[3], 1'b0, e.q[31], (e.q == 0)};
    e.due = cyc + ((dvs == 0) ? 1 : LAT_RUN);
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk("R1 unexpected completion", 1, 0);
        end else begin
          got = sb.pop_front();
          chk("R3 latency", 64'(cyc), 64'(got.due));
          chk("R6/R7 quo_we", quo_we, got.qwe);
          chk("R6/R7 rem_we", rem_we, got.rwe);
          chk("R4/R5 flags", flags_out, got.fl);
          if (got.qwe) begin
            chk("R2 quo index", quo_widx, got.qi);
            chk("R2 quotient", quo_wdata, got.q);
          end
          if (got.rwe) begin
            chk("R2 rem index", rem_widx, got.ri);
            chk("R2 remainder", rem_wdata, got.r);
          end
        end
      end else if (quo_we || rem_we) begin
        chk("R8 write without done", {quo_we, rem_we}, 2'b00);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset ready", in_ready, 1'b1);
    chk("R8 reset done", done, 1'b0);
    chk("R8 reset we", {quo_we, rem_we}, 2'b00);

    send(32'd6, 32'd45, 5'd2, 5'd3, 5'b00000);           // R2: 7 rem 3
    send(32'd4, 32'h4000_0000, 5'd2, 5'd3, 5'b00000);     // R2: exact, flags clear
    send(32'd0, 32'd45, 5'd2, 5'd3, 5'b00000);           // R4: only OV set
    send(32'd0, 32'd45, 5'd2, 5'd3, 5'b11111);           // R4: all flags kept
    send(32'd45, 32'd0, 5'd1, 5'd3, 5'b00000);           // R9: zero dividend, Z=1
    send(32'd45, 32'd16, 5'd2, 5'd3, 5'b00010);          // R5: Z from quotient, rem 16
    send(32'd6, 32'd45, 5'd2, 5'd2, 5'b00000);           // R6: same register gets 3
    send(32'd1, 32'hFFFF_FFFF, 5'd7, 5'd8, 5'b11000);    // R5: S=1, CY/SAT pass
    send(32'd3, 32'd100, 5'd0, 5'd5, 5'b00000);          // R7: quotient to r0 dropped
    send(32'd3, 32'd100, 5'd4, 5'd0, 5'b00000);          // R7: remainder to r0 dropped
    send(32'h1234, 32'hDEAD_BEEF, 5'd9, 5'd10, 5'b00101);// R2/R5: wide operands

    // R1: offers during a run are dropped
    send(32'd7, 32'd100, 5'd11, 5'd12, 5'b00000);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; divisor = 32'd0; dividend = 32'd999;
      quo_idx = 5'd13; rem_idx = 5'd14; flags_in = 5'b11111;
      @(negedge clk);
      chk("R1 busy not ready", in_ready, 1'b0);
    end
    in_valid = 1'b0;

    send(32'hFFFF_FFFF, 32'hFFFF_FFFE, 5'd15, 5'd16, 5'b00000); // R2: divisor > dividend

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule